// File: doc/BRIEF.md
# Receive Window Exit Controller

This block watches one receive window of a radio and decides when the window stops and where the radio goes next. A window opens on a start pulse. It can end in three ways. A carrier-sense sample can report no carrier. The receive timer can expire with no qualifying sign of a packet. The packet path can report that receive finished normally.

For each exit the block issues one request pulse with an encoded next state. An early exit (no carrier, or timeout without qualification) goes to IDLE, or to SLEEP when wake-on-radio is active. A normal finish goes to the configured post-receive state. A normal finish also clears the wake-on-radio state, so later early exits go to IDLE until wake-on-radio is armed again.

With on-off keying, a carrier-sense sample only counts once eight symbol periods have passed in the window. Earlier samples are ignored.

Top module: `rx_exit_ctrl`

## Requirements
- R1: With `cfg_qual_sel`=0, a `rx_timeout` pulse inside a window ends it unless `sync_found` is high in that cycle; with sync high the window continues.
- R2: With `cfg_qual_sel`=1, a `rx_timeout` pulse is survived if `sync_found` or `pqt_ok` is high; only when both are low does the window end.
- R3: With `cfg_rssi_term`=1, the first qualified `cs_valid` sample of a window ends it if `cs_carrier`=0. If that first sample shows carrier, no later sample in the same window ends it.
- R4: With `mod_ook`=1, `cs_valid` samples seen before eight `sym_tick` pulses have been counted since the window opened are ignored and do not use up the first-sample decision. The ninth-tick count saturates at eight.
- R5: An exit from no carrier or from timeout requests state 3'b000 (IDLE) when wake-on-radio is inactive, and 3'b001 (SLEEP) when it is active.
- R6: A `rx_done` pulse inside a window ends it and requests state {1'b1, cfg_rxoff}.
- R7: Wake-on-radio becomes active on a rising edge of `cfg_wor_en` and inactive whenever `cfg_wor_en` is low. A normal finish while it is active pulses `wor_cleared` with the request and deactivates it.
- R8: Each exit gives exactly one single-cycle `req_valid`, one cycle after the deciding input. No request is made outside a window, and `rx_start` during an open window is ignored.
- R9: When exit causes coincide, no carrier wins over timeout, and timeout wins over normal finish.
- R10: After reset no window is open and `req_valid` and `wor_cleared` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_start | input | 1 | Opens a receive window |
| rx_done | input | 1 | Receive finished normally |
| rx_timeout | input | 1 | Receive timer expired |
| sync_found | input | 1 | Sync word seen |
| pqt_ok | input | 1 | Preamble quality above threshold |
| cs_valid | input | 1 | Carrier-sense sample strobe |
| cs_carrier | input | 1 | Sample shows carrier |
| mod_ook | input | 1 | On-off keying in use |
| sym_tick | input | 1 | One symbol period elapsed |
| cfg_qual_sel | input | 1 | Timeout qualifier select |
| cfg_rssi_term | input | 1 | No-carrier termination enable |
| cfg_wor_en | input | 1 | Wake-on-radio enable |
| cfg_rxoff | input | 2 | Post-receive state code |
| req_valid | output | 1 | Next-state request pulse |
| req_state | output | 3 | Requested state code |
| wor_cleared | output | 1 | Wake-on-radio state was cleared |

## Verification
Random windows vary the qualifier select, sync and preamble flags at timeout. This tells the sync-only rule apart from the sync-or-preamble rule. Carrier samples arrive with and without on-off keying at random symbol counts, which separates samples that are ignored, samples that decide, and samples that come after the decision. Directed cases cover seven versus eight symbol ticks, all three causes in one cycle, and a normal finish under wake-on-radio followed by an early exit that must fall back to IDLE. Noise pulses outside a window check that no request appears there.

// File: rtl/rx_exit_pkg.sv
// Shared types and state codes of the receive window exit controller.
// Assumes a 3-bit next-state code where bit 2 marks the configured state.
package rx_exit_pkg;
    localparam int RXOFF_W = 2;
    localparam int STATE_W = RXOFF_W + 1;

    typedef enum logic [1:0] {
        CAUSE_NONE      = 2'd0,
        CAUSE_NOCARRIER = 2'd1,
        CAUSE_TIMEOUT   = 2'd2,
        CAUSE_DONE      = 2'd3
    } exit_cause_t;

    localparam logic [STATE_W-1:0] ST_IDLE  = 3'b000;
    localparam logic [STATE_W-1:0] ST_SLEEP = 3'b001;

    // Maps the configured post-receive code into the request encoding.
    function automatic logic [STATE_W-1:0] post_state(input logic [RXOFF_W-1:0] code);
        return {1'b1, code};
    endfunction
endpackage

// File: rtl/rx_sym_counter.sv
// Saturating count of symbol ticks since the window opened.
// Assumes clear and tick are never needed in the same cycle (clear wins).
module rx_sym_counter #(
    parameter int MIN_SYM = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic en,
    input  logic tick,
    output logic sat
);
    localparam int CNT_W = $clog2(MIN_SYM + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_SYM);

    logic [CNT_W-1:0] cnt;

    // Counts ticks inside the window and stops at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt <= '0;
        else if (clear)                       cnt <= '0;
        else if (en && tick && cnt != LIMIT)  cnt <= cnt + 1'b1;
    end

    assign sat = (cnt == LIMIT);
endmodule

// File: rtl/rx_exit_arbiter.sv
// Combinational choice of the exit cause for the current cycle.
// Assumes all inputs are sampled in the same cycle; no carrier beats
// timeout, which beats normal finish.
module rx_exit_arbiter
    import rx_exit_pkg::*;
(
    input  logic        in_rx,
    input  logic        cs_pending,
    input  logic        rx_done,
    input  logic        rx_timeout,
    input  logic        sync_found,
    input  logic        pqt_ok,
    input  logic        cfg_qual_sel,
    input  logic        cfg_rssi_term,
    input  logic        cs_valid,
    input  logic        cs_carrier,
    input  logic        mod_ook,
    input  logic        sym_sat,
    output logic        cs_consume,
    output exit_cause_t cause
);
    logic cs_qualified;
    logic qual_hold;
    logic nocarrier_hit;
    logic timeout_hit;

    // Qualifies carrier samples and the timeout survival condition.
    always_comb begin
        cs_qualified  = cs_valid && (!mod_ook || sym_sat);
        cs_consume    = in_rx && cs_pending && cs_qualified;
        nocarrier_hit = cs_consume && cfg_rssi_term && !cs_carrier;
        qual_hold     = sync_found || (cfg_qual_sel && pqt_ok);
        timeout_hit   = in_rx && rx_timeout && !qual_hold;
    end

    // Picks the winning cause by fixed priority.
    always_comb begin
        if (nocarrier_hit)          cause = CAUSE_NOCARRIER;
        else if (timeout_hit)       cause = CAUSE_TIMEOUT;
        else if (in_rx && rx_done)  cause = CAUSE_DONE;
        else                        cause = CAUSE_NONE;
    end
endmodule

// File: rtl/rx_exit_request.sv
// Registers the next-state request and keeps the wake-on-radio state.
// Assumes cause is non-NONE for at most one cycle per window.
module rx_exit_request
    import rx_exit_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  exit_cause_t        cause,
    input  logic               cfg_wor_en,
    input  logic [RXOFF_W-1:0] cfg_rxoff,
    output logic               req_valid,
    output logic [STATE_W-1:0] req_state,
    output logic               wor_cleared
);
    logic wor_active;
    logic wor_en_q;
    logic is_done;

    assign is_done = (cause == CAUSE_DONE);

    // Tracks arming on a rising enable and clearing on a normal finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wor_active <= 1'b0;
            wor_en_q   <= 1'b0;
        end else begin
            wor_en_q <= cfg_wor_en;
            if (!cfg_wor_en)                   wor_active <= 1'b0;
            else if (!wor_en_q)                wor_active <= 1'b1;
            else if (is_done)                  wor_active <= 1'b0;
        end
    end

    // Issues one request pulse with the encoded destination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid   <= 1'b0;
            req_state   <= ST_IDLE;
            wor_cleared <= 1'b0;
        end else begin
            req_valid   <= (cause != CAUSE_NONE);
            wor_cleared <= is_done && wor_active;
            if (is_done)                     req_state <= post_state(cfg_rxoff);
            else if (cause != CAUSE_NONE)    req_state <= wor_active ? ST_SLEEP : ST_IDLE;
        end
    end
endmodule

// File: rtl/rx_exit_ctrl.sv
// Top of the receive window exit controller: keeps the window open flag
// and the first-sample flag, and joins counter, arbiter and request stage.
// Assumes rx_start is a single-cycle pulse; it is ignored while open.
module rx_exit_ctrl
    import rx_exit_pkg::*;
#(
    parameter int OOK_MIN_SYM = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_start,
    input  logic               rx_done,
    input  logic               rx_timeout,
    input  logic               sync_found,
    input  logic               pqt_ok,
    input  logic               cs_valid,
    input  logic               cs_carrier,
    input  logic               mod_ook,
    input  logic               sym_tick,
    input  logic               cfg_qual_sel,
    input  logic               cfg_rssi_term,
    input  logic               cfg_wor_en,
    input  logic [RXOFF_W-1:0] cfg_rxoff,
    output logic               req_valid,
    output logic [STATE_W-1:0] req_state,
    output logic               wor_cleared
);
    logic        in_rx;
    logic        cs_pending;
    logic        start_acc;
    logic        sym_sat;
    logic        cs_consume;
    exit_cause_t cause;

    assign start_acc = rx_start && !in_rx;

    // Opens the window on an accepted start, closes it on any exit.
    always_ff @(posedge clk) begin
        if (!rst_n)                   in_rx <= 1'b0;
        else if (cause != CAUSE_NONE) in_rx <= 1'b0;
        else if (start_acc)           in_rx <= 1'b1;
    end

    // Remembers that the deciding carrier sample has not yet arrived.
    always_ff @(posedge clk) begin
        if (!rst_n)          cs_pending <= 1'b0;
        else if (start_acc)  cs_pending <= 1'b1;
        else if (cs_consume) cs_pending <= 1'b0;
    end

    rx_sym_counter #(.MIN_SYM(OOK_MIN_SYM)) u_sym (
        .clk(clk), .rst_n(rst_n), .clear(start_acc), .en(in_rx),
        .tick(sym_tick), .sat(sym_sat)
    );

    rx_exit_arbiter u_arb (
        .in_rx(in_rx), .cs_pending(cs_pending), .rx_done(rx_done),
        .rx_timeout(rx_timeout), .sync_found(sync_found), .pqt_ok(pqt_ok),
        .cfg_qual_sel(cfg_qual_sel), .cfg_rssi_term(cfg_rssi_term),
        .cs_valid(cs_valid), .cs_carrier(cs_carrier), .mod_ook(mod_ook),
        .sym_sat(sym_sat), .cs_consume(cs_consume), .cause(cause)
    );

    rx_exit_request u_req (
        .clk(clk), .rst_n(rst_n), .cause(cause), .cfg_wor_en(cfg_wor_en),
        .cfg_rxoff(cfg_rxoff), .req_valid(req_valid), .req_state(req_state),
        .wor_cleared(wor_cleared)
    );
endmodule

// File: rtl/rx_exit_checker.sv
// Property checker for the exit controller, bound to every instance.
// Assumes visibility of the window open flag through the bind.
module rx_exit_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_rx,
    input logic       rx_start,
    input logic       req_valid,
    input logic [2:0] req_state,
    input logic       wor_cleared
);
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid); // R8
    AST_REQ_FROM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $past(in_rx)); // R8
    AST_EXIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !in_rx); // R8
    AST_CLEAR_ON_POST: assert property (@(posedge clk) disable iff (!rst_n)
        wor_cleared |-> (req_valid && req_state[2])); // R7
    AST_EARLY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_state[2]) |-> !req_state[1]); // R5
    AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_start && !in_rx) |=> in_rx); // R8
endmodule

bind rx_exit_ctrl rx_exit_checker u_chk (
    .clk(clk), .rst_n(rst_n), .in_rx(in_rx), .rx_start(rx_start),
    .req_valid(req_valid), .req_state(req_state), .wor_cleared(wor_cleared)
);

// File: tb/rx_exit_ctrl_test.sv
module rx_exit_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_start = 0, rx_done = 0, rx_timeout = 0, sync_found = 0, pqt_ok = 0;
    logic cs_valid = 0, cs_carrier = 0, mod_ook = 0, sym_tick = 0;
    logic cfg_qual_sel = 0, cfg_rssi_term = 0, cfg_wor_en = 0;
    logic [1:0] cfg_rxoff = 2'b00;
    logic req_valid, wor_cleared;
    logic [2:0] req_state;

    int total = 0, bad = 0;
    // reference model state
    bit m_in = 0, m_pend = 0, m_wor = 0, m_wen_q = 0;
    int m_cnt = 0;
    bit e_valid = 0, e_clr = 0, last_exit = 0;
    logic [2:0] e_state = 3'b000;
    string e_tag = "R8";

    rx_exit_ctrl uut (.*);

    always #4 clk = ~clk;

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog R8 actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Cause code from the requirements: 0 none, 1 no carrier, 2 timeout, 3 done.
    function automatic int ref_cause();
        bit qual = cs_valid && (!mod_ook || m_cnt >= 8);
        bit nc = m_in && m_pend && qual && cfg_rssi_term && !cs_carrier;
        bit to = m_in && rx_timeout && !(sync_found || (cfg_qual_sel && pqt_ok));
        if (nc) return 1;
        if (to) return 2;
        if (m_in && rx_done) return 3;
        return 0;
    endfunction

    // One clock: predict, advance the model, compare after the edge.
    task automatic cyc();
        int c = ref_cause();
        bit qual = cs_valid && (!mod_ook || m_cnt >= 8);
        bit multi = (c != 0) && ((m_in && rx_timeout) + (m_in && rx_done) + qual > 1);
        e_valid = (c != 0);
        e_clr = (c == 3) && m_wor;
        if (c == 3) e_state = {1'b1, cfg_rxoff};
        else if (c != 0) e_state = m_wor ? 3'b001 : 3'b000;
        e_tag = multi ? "R9" : c == 1 ? (mod_ook ? "R4" : "R3") :
                c == 2 ? (cfg_qual_sel ? "R2" : "R1") : c == 3 ? "R6" : "R8";
        if (e_valid && c != 3) e_tag = {e_tag, "/R5"};
        if (e_clr) e_tag = {e_tag, "/R7"};
        // model update
        if (m_in && m_pend && qual) m_pend = 0;
        if (rx_start && !m_in) begin m_in = 1; m_pend = 1; m_cnt = 0; end
        else if (m_in && sym_tick && m_cnt < 8) m_cnt++;
        if (c != 0) m_in = 0;
        if (!cfg_wor_en) m_wor = 0;
        else if (!m_wen_q) m_wor = 1;
        else if (c == 3) m_wor = 0;
        m_wen_q = cfg_wor_en;
        last_exit = e_valid;
        @(posedge clk); #1;
        check(req_valid == e_valid, e_tag, req_valid, e_valid);
        check(wor_cleared == e_clr, e_tag, wor_cleared, e_clr);
        if (e_valid) check(req_state == e_state, e_tag, req_state, e_state);
        @(negedge clk);
        {rx_start, rx_done, rx_timeout, cs_valid, sym_tick} = '0;
    endtask

    task automatic open_win();
        rx_start = 1; cyc();
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(req_valid == 0 && wor_cleared == 0, "R10", req_valid, 0);
        // R8: noise outside a window is ignored
        rx_done = 1; rx_timeout = 1; cs_valid = 1; cyc();
        // R1: timeout with sync continues, without sync ends
        open_win(); sync_found = 1; rx_timeout = 1; cyc();
        sync_found = 0; rx_timeout = 1; cyc();
        // R2: preamble quality holds only with qual_sel=1
        cfg_qual_sel = 1; open_win(); pqt_ok = 1; rx_timeout = 1; cyc();
        pqt_ok = 0; rx_timeout = 1; cyc();
        // R4: seven ticks then sample ignored, eighth tick then sample decides
        cfg_rssi_term = 1; mod_ook = 1; open_win();
        for (int i = 0; i < 7; i++) begin sym_tick = 1; cyc(); end
        cs_valid = 1; cs_carrier = 0; cyc();
        sym_tick = 1; cyc(); cs_valid = 1; cyc();
        mod_ook = 0;
        // R3: first sample with carrier disarms later samples
        open_win(); cs_valid = 1; cs_carrier = 1; cyc();
        cs_valid = 1; cs_carrier = 0; cyc(); rx_done = 1; cfg_rxoff = 2'b10; cyc();
        // R9: all three causes together
        open_win(); cs_valid = 1; rx_timeout = 1; rx_done = 1; cyc();
        // R7: arm wake-on-radio, early exit to SLEEP, normal finish clears, then IDLE
        cfg_wor_en = 1; cyc();
        open_win(); rx_timeout = 1; cyc();
        open_win(); rx_done = 1; cfg_rxoff = 2'b01; cyc();
        open_win(); rx_timeout = 1; cyc();
        cfg_wor_en = 0; cyc(); cfg_wor_en = 1; cyc();
        open_win(); cs_valid = 1; cs_carrier = 0; cyc();
        // random windows
        for (int t = 0; t < 400; t++) begin
            cfg_qual_sel = $urandom_range(0, 1); cfg_rssi_term = $urandom_range(0, 1);
            mod_ook = $urandom_range(0, 1); cfg_rxoff = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 7) == 0) cfg_wor_en = ~cfg_wor_en;
            rx_done = ($urandom_range(0, 3) == 0); cyc();
            open_win();
            for (int k = 0; k < 40 && m_in; k++) begin
                sync_found = ($urandom_range(0, 3) == 0);
                pqt_ok = ($urandom_range(0, 2) == 0);
                sym_tick = $urandom_range(0, 1);
                cs_valid = ($urandom_range(0, 4) == 0);
                cs_carrier = $urandom_range(0, 1);
                rx_timeout = ($urandom_range(0, 14) == 0);
                rx_done = ($urandom_range(0, 14) == 0);
                rx_start = ($urandom_range(0, 9) == 0);
                cyc();
            end
            if (m_in) begin rx_done = 1; cyc(); end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule